// File: doc/BRIEF.md
# Multiplexed Bus Port Controller

This block owns two 8-bit pin groups, port A and port B, that serve either as the lines of a multiplexed external address/data bus or as general-purpose outputs. A strap input, sampled continuously, picks the role. With the strap high, the block hands the pins to the external bus engine. It passes that engine's output-enable and output-data through unchanged. Any register access aimed at a port data register is turned into a one-cycle bus-cycle request that carries the register's own address.

With the strap low, each port drives its data register onto its pins. A drive-control register selects open-drain or push-pull drive for each port. In open-drain drive a 1 bit releases the pin and a 0 bit pulls it low. Both data registers reset to all ones and drive control resets to open-drain, so the pins float after reset until software or external pull-ups decide their level. In this mode, reads of a data register return the live pin levels.

Top module: `mbus_port_ctl`

## Requirements
- R1: After reset, with the strap low, both data registers hold FFH and the drive-control register holds 00H, so all sixteen pins have output enable low.
- R2: With the strap low and the port's drive-control bit at 0 (open-drain), pin i of that port has output enable high exactly when data bit i is 0, and its output data equals the data bit.
- R3: Drive-control bit 0 selects push-pull for port A and bit 1 for port B. With the bit at 1 and the strap low, all eight pins of that port are enabled and carry the data register.
- R4: With the strap low, a write to address 1FFCH loads port A's data register and a write to 1FFDH loads port B's. The update takes effect on the pins one cycle later.
- R5: With the strap low, a read of 1FFCH or 1FFDH returns the current pin input levels of that port, not the register contents.
- R6: The drive-control register at 1FF0H can be written and read back in either strap state. All eight bits are stored.
- R7: With the strap high, each port's output enable and output data equal the bus engine's inputs for that port. When the engine's enables are low, the pins float whatever the port registers hold.
- R8: With the strap high, a read or write of 1FFCH or 1FFDH produces, one cycle later, a single-cycle request with the same address, the direction (1 = write), and for writes the written data. No request is ever produced with the strap low or for any other address.
- R9: With the strap high, writes to the data registers leave them unchanged. After the strap returns low, the pins show the values held before.
- R10: With the strap high, a read of a data register address returns the bus engine's read-data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_bus | input | 1 | High: pins belong to the external bus |
| reg_addr | input | 16 | Register access address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pb_in | input | 8 | Port B pin levels |
| pa_oe | output | 8 | Port A per-pin output enable |
| pa_out | output | 8 | Port A pin output data |
| pb_oe | output | 8 | Port B per-pin output enable |
| pb_out | output | 8 | Port B pin output data |
| bus_oe_a | input | 8 | Bus engine enable for port A pins |
| bus_do_a | input | 8 | Bus engine data for port A pins |
| bus_oe_b | input | 8 | Bus engine enable for port B pins |
| bus_do_b | input | 8 | Bus engine data for port B pins |
| bus_rdata | input | 8 | Data returned by the bus engine |
| cyc_req | output | 1 | One-cycle bus-cycle request |
| cyc_wr | output | 1 | Request direction, 1 = write |
| cyc_addr | output | 16 | Request address |
| cyc_wdata | output | 8 | Request write data |

## Verification
A corrupted data or drive-control register shows on the enables and data of the port pins in the very next cycle in port mode. In bus mode the same corruption stays hidden until the strap drops, so the bench writes in bus mode and then leaves it to expose it. A wrong decision in the request path shows one cycle after the access, as a missing, extra or mis-addressed request pulse. The bench models pull-ups, so read-back reveals whether the enable pattern matches the data.

// File: rtl/mbus_port_ctl.sv
module mbus_port_ctl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] PA_ADDR  = 16'h1FFC,
  parameter logic [AW-1:0] PB_ADDR  = 16'h1FFD,
  parameter logic [AW-1:0] DRV_ADDR = 16'h1FF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_bus,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] pa_in,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pa_oe,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pb_oe,
  output logic [DW-1:0] pb_out,
  input  logic [DW-1:0] bus_oe_a,
  input  logic [DW-1:0] bus_do_a,
  input  logic [DW-1:0] bus_oe_b,
  input  logic [DW-1:0] bus_do_b,
  input  logic [DW-1:0] bus_rdata,
  output logic          cyc_req,
  output logic          cyc_wr,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_wdata
);

  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic [DW-1:0] pa_q, pb_q, drv_q;
  logic hit_a, hit_b, hit_d, acc;

  assign hit_a = reg_addr == PA_ADDR;
  assign hit_b = reg_addr == PB_ADDR;
  assign hit_d = reg_addr == DRV_ADDR;
  assign acc   = reg_wr | reg_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q  <= ONES;
      pb_q  <= ONES;
      drv_q <= '0;
    end else if (reg_wr) begin
      if (hit_a && !strap_bus) pa_q <= reg_wdata;
      if (hit_b && !strap_bus) pb_q <= reg_wdata;
      if (hit_d) drv_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_req   <= 1'b0;
      cyc_wr    <= 1'b0;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
    end else begin
      cyc_req <= strap_bus && acc && (hit_a || hit_b);
      if (strap_bus && acc && (hit_a || hit_b)) begin
        cyc_wr    <= reg_wr;
        cyc_addr  <= reg_addr;
        cyc_wdata <= reg_wr ? reg_wdata : '0;
      end
    end
  end

  assign pa_oe  = strap_bus ? bus_oe_a : ({DW{drv_q[0]}} | ~pa_q);
  assign pa_out = strap_bus ? bus_do_a : pa_q;
  assign pb_oe  = strap_bus ? bus_oe_b : ({DW{drv_q[1]}} | ~pb_q);
  assign pb_out = strap_bus ? bus_do_b : pb_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_d)      reg_rdata = drv_q;
      else if (hit_a) reg_rdata = strap_bus ? bus_rdata : pa_in;
      else if (hit_b) reg_rdata = strap_bus ? bus_rdata : pb_in;
    end
  end

  // R8
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> $past(strap_bus && (reg_wr || reg_rd) &&
                      (reg_addr == PA_ADDR || reg_addr == PB_ADDR)));
  // R8
  req_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && cyc_wr) |-> (cyc_wdata == $past(reg_wdata) && cyc_addr == $past(reg_addr)));
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_bus && reg_wr && (hit_a || hit_b)) |=> ($stable(pa_q) && $stable(pb_q)));
  // R2
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_bus && !drv_q[0]) |-> ((pa_oe | pa_out) == ONES && (pa_oe & pa_out) == '0));
  // R3
  pp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_bus && drv_q[1]) |-> pb_oe == ONES);

endmodule

// File: tb/sim_mbus_port_ctl.sv
module sim_mbus_port_ctl;
  logic clk = 0, rst_n = 0, strap_bus = 0;
  logic [15:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [7:0] pa_in, pb_in, pa_oe, pa_out, pb_oe, pb_out;
  logic [7:0] bus_oe_a = 0, bus_do_a = 0, bus_oe_b = 0, bus_do_b = 0, bus_rdata = 0;
  logic cyc_req, cyc_wr;
  logic [15:0] cyc_addr;
  logic [7:0] cyc_wdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // pull-up model: released pins read high
  assign pa_in = (pa_oe & pa_out) | ~pa_oe;
  assign pb_in = (pb_oe & pb_out) | ~pb_oe;

  mbus_port_ctl u0 (.clk, .rst_n, .strap_bus, .reg_addr, .reg_wr, .reg_rd,
    .reg_wdata, .reg_rdata, .pa_in, .pb_in, .pa_oe, .pa_out, .pb_oe, .pb_out,
    .bus_oe_a, .bus_do_a, .bus_oe_b, .bus_do_b, .bus_rdata,
    .cyc_req, .cyc_wr, .cyc_addr, .cyc_wdata);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write; on return we are one negedge after the edge that took it
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'hFF);
    rd(16'h1FF0, d); chk("R1 drv", d, 8'h00);
    chk("R8 no req", cyc_req, 0);
  endtask

  task automatic t_open_drain;
    logic [7:0] d;
    wr(16'h1FFC, 8'hA5);
    chk("R4 pa_out", pa_out, 8'hA5);
    chk("R2 pa_oe", pa_oe, 8'h5A);
    chk("R8 none in port mode", cyc_req, 0);
    wr(16'h1FFD, 8'h0F);
    chk("R2 pb_oe", pb_oe, 8'hF0);
    rd(16'h1FFC, d); chk("R5 pa pins", d, 8'hA5);
    rd(16'h1FFD, d); chk("R5 pb pins", d, 8'h0F);
  endtask

  task automatic t_push_pull;
    logic [7:0] d;
    wr(16'h1FF0, 8'h01);
    chk("R3 pa pp oe", pa_oe, 8'hFF);
    chk("R3 pb still od", pb_oe, 8'hF0);
    wr(16'h1FF0, 8'hC2);
    chk("R3 pb pp oe", pb_oe, 8'hFF);
    chk("R3 pa back od", pa_oe, 8'h5A);
    rd(16'h1FF0, d); chk("R6 drv readback", d, 8'hC2);
    wr(16'h1FF0, 8'h00);
  endtask

  task automatic t_bus_mode;
    logic [7:0] d;
    @(negedge clk); strap_bus = 1; bus_oe_a = 8'h00; bus_oe_b = 8'h00;
    bus_do_a = 8'h3C; bus_do_b = 8'hC3; bus_rdata = 8'h77;
    #1 chk("R7 idle float a", pa_oe, 8'h00);
    chk("R7 idle float b", pb_oe, 8'h00);
    bus_oe_a = 8'hFF; bus_oe_b = 8'h0F;
    #1 chk("R7 pa_out", pa_out, 8'h3C);
    chk("R7 pb_oe", pb_oe, 8'h0F);
    wr(16'h1FFD, 8'h12);
    chk("R8 req", cyc_req, 1);
    chk("R8 wr", cyc_wr, 1);
    chk("R8 addr", cyc_addr, 16'h1FFD);
    chk("R8 wdata", cyc_wdata, 8'h12);
    @(negedge clk); chk("R8 single pulse", cyc_req, 0);
    rd(16'h1FFC, d);
    chk("R10 rdata", d, 8'h77);
    chk("R8 rd req", cyc_req, 1);
    chk("R8 rd dir", cyc_wr, 0);
    chk("R8 rd addr", cyc_addr, 16'h1FFC);
    wr(16'h1FFC, 8'h00);
    wr(16'h1FF0, 8'h55);
    chk("R8 drv no req", cyc_req, 0);
    rd(16'h1FF0, d); chk("R6 drv in bus mode", d, 8'h55);
    wr(16'h1FF0, 8'h00);
    @(negedge clk); strap_bus = 0;
    #1 chk("R9 pa kept", pa_out, 8'hA5);
    chk("R9 pb kept", pb_out, 8'h0F);
    wr(16'h1FFC, 8'h00);
    chk("R8 port mode no req", cyc_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_open_drain;
    t_push_pull;
    t_bus_mode;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule